// File: doc/BRIEF.md
# Multi-Domain Clock Ratio Controller

This block derives three clock-enable streams from a single master clock: one for the core and every bus master, one for on-chip peripherals, and one for the external bus. Each stream is a single-cycle pulse that repeats at a power-of-two fraction of the master rate. Software picks each ratio by writing a 3-bit select code into one control register. Downstream logic uses the enables to advance its registers.

A written setting is held in a shadow copy and reaches the dividers only when the bus reports the end of its current cycle. This keeps a running transfer from seeing its clock change partway through. The peripheral and external-bus ratios are clamped so that neither domain ever runs faster than the core domain. All three streams come from one shared base counter, so their pulses always line up.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the register reads 0x049. All three select fields hold code 1 (divide-by-2). The core select sits in bits [2:0], the peripheral select in bits [5:3] and the external-bus select in bits [8:6].
- R2: A write sets `cfg_rdata` to the written value from the next cycle on. The read value is the raw written codes, not the clamped ones.
- R3: A write changes no enable output until `cycle_end` has been seen high.
- R4: The shadow value is copied to the dividers on a clock edge where `cycle_end` is high. A write in that same cycle is used only at a later `cycle_end`.
- R5: Select codes 0, 1, 2, 3 and 4 give division ratios of 1, 2, 4, 8 and 16. Over any 32 consecutive cycles a domain then shows 32/ratio pulses.
- R6: Reserved select codes 5, 6 and 7 divide by 16.
- R7: If the peripheral select asks for a faster rate than the core select, the peripheral enable runs at the core rate.
- R8: If the external-bus select asks for a faster rate than the core select, the external-bus enable runs at the core rate.
- R9: All domains are phase-aligned to one base counter. A peripheral or external-bus pulse never occurs without a core pulse in the same cycle.
- R10: At any ratio above 1, each enable pulse is exactly one master-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 9 | Write data: three 3-bit select fields |
| cycle_end | input | 1 | High in the last cycle of a bus transfer |
| cfg_rdata | output | 9 | Read-back of the written select fields |
| core_en | output | 1 | Core and bus-master clock enable |
| per_en | output | 1 | Peripheral clock enable |
| ext_en | output | 1 | External-bus clock enable |

## Verification
The hardest case to reach is a write that lands in the same cycle as `cycle_end`. The dividers must keep the old shadow value, and the new value must wait for the following bus-cycle end. The bench drives both strobes on one edge and measures pulse counts before and after a second `cycle_end`. The clamp is checked with core codes that are slower than the requested peripheral and external-bus codes, including reserved codes. Pulse rates are measured over 32-cycle windows, so the result does not depend on phase.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
   typedef enum int {
      DOM_CORE = 0,
      DOM_PER  = 1,
      DOM_EXT  = 2
   } dom_e;

   localparam int NUM_DOM = 3;

   // Map a select code onto a log2 division ratio, saturating at max_log.
   function automatic int sel_to_log(int code, int max_log);
      return (code > max_log) ? max_log : code;
   endfunction
endpackage

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs #(
   parameter int SEL_W    = 3,
   parameter int NUM_DOM  = 3,
   parameter int RST_CODE = 1,
   localparam int REG_W   = SEL_W * NUM_DOM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             cycle_end,
   output logic [REG_W-1:0] shadow_q,
   output logic [REG_W-1:0] active_q
);
   localparam logic [REG_W-1:0] RST_VAL = {NUM_DOM{RST_CODE[SEL_W-1:0]}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST_VAL;
         active_q <= RST_VAL;
      end else begin
         if (wr)
            shadow_q <= wdata;
         if (cycle_end)
            active_q <= shadow_q;
      end
   end
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
   parameter int SEL_W   = 3,
   parameter int MAX_LOG = 4,
   parameter bit CLAMP   = 1'b0
) (
   input  logic [MAX_LOG-1:0] base_cnt,
   input  logic [SEL_W-1:0]   sel,
   input  logic [SEL_W-1:0]   ref_sel,
   output logic               en
);
   import clk_ratio_pkg::*;

   int                 own_log;
   int                 eff_log;
   logic [MAX_LOG-1:0] mask;

   assign own_log = sel_to_log(int'(sel), MAX_LOG);

   generate
      if (CLAMP) begin : g_clamp
         int ref_log;
         assign ref_log = sel_to_log(int'(ref_sel), MAX_LOG);
         assign eff_log = (own_log < ref_log) ? ref_log : own_log;
      end else begin : g_free
         assign eff_log = own_log;
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < MAX_LOG; i++)
         mask[i] = (i < eff_log);
   end

   assign en = ((base_cnt & mask) == '0);
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl #(
   parameter int SEL_W    = 3,
   parameter int MAX_LOG  = 4,
   parameter int RST_CODE = 1,
   localparam int REG_W   = SEL_W * clk_ratio_pkg::NUM_DOM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             cycle_end,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             core_en,
   output logic             per_en,
   output logic             ext_en
);
   import clk_ratio_pkg::*;

   generate
      if (SEL_W < 1 || MAX_LOG < 1 || MAX_LOG >= (1 << SEL_W) + 1)
         $error("clk_ratio_ctrl: SEL_W/MAX_LOG out of range");
      if (RST_CODE < 0 || RST_CODE >= (1 << SEL_W))
         $error("clk_ratio_ctrl: RST_CODE does not fit SEL_W");
   endgenerate

   logic [REG_W-1:0]   act_cfg;
   logic [MAX_LOG-1:0] base_cnt;
   logic [NUM_DOM-1:0] en_vec;

   clk_ratio_regs #(
      .SEL_W(SEL_W), .NUM_DOM(NUM_DOM), .RST_CODE(RST_CODE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .cycle_end(cycle_end), .shadow_q(cfg_rdata), .active_q(act_cfg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_cnt <= '0;
      else        base_cnt <= base_cnt + 1'b1;
   end

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         clk_ratio_div #(
            .SEL_W(SEL_W), .MAX_LOG(MAX_LOG), .CLAMP(d != DOM_CORE)
         ) div_i (
            .base_cnt(base_cnt),
            .sel(act_cfg[d*SEL_W +: SEL_W]),
            .ref_sel(act_cfg[DOM_CORE*SEL_W +: SEL_W]),
            .en(en_vec[d])
         );
      end
   endgenerate

   assign core_en = en_vec[DOM_CORE];
   assign per_en  = en_vec[DOM_PER];
   assign ext_en  = en_vec[DOM_EXT];
endmodule

// File: rtl/clk_ratio_chk.sv
module clk_ratio_chk #(
   parameter int SEL_W = 3,
   parameter int REG_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [REG_W-1:0] cfg_wdata,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             cycle_end,
   input logic [REG_W-1:0] act_cfg,
   input logic             core_en,
   input logic             per_en,
   input logic             ext_en
);
   // R2
   rdata_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rdata == $past(cfg_wdata));

   // R3
   active_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(act_cfg));

   // R4
   active_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> act_cfg == $past(cfg_rdata));

   // R7
   per_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_en |-> core_en);

   // R8
   ext_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en |-> core_en);

   // R10
   core_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_en && act_cfg[SEL_W-1:0] != '0 && !cycle_end) |=> !core_en);
endmodule

bind clk_ratio_ctrl clk_ratio_chk #(.SEL_W(SEL_W), .REG_W(REG_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
   .cfg_rdata(cfg_rdata), .cycle_end(cycle_end), .act_cfg(act_cfg),
   .core_en(core_en), .per_en(per_en), .ext_en(ext_en)
);

// File: tb/clk_ratio_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [8:0] cfg_wdata = '0;
   logic       cycle_end = 1'b0;
   logic [8:0] cfg_rdata;
   logic       core_en, per_en, ext_en;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   clk_ratio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cycle_end(cycle_end), .cfg_rdata(cfg_rdata),
      .core_en(core_en), .per_en(per_en), .ext_en(ext_en)
   );

   // {cfg(9), exp core, exp per, exp ext (6 each)}; cfg = {ext, per, core}
   localparam logic [26:0] VEC [6] = '{
      {3'd0, 3'd0, 3'd0, 6'd32, 6'd32, 6'd32},  // R5 divide-by-1
      {3'd4, 3'd3, 3'd2, 6'd8,  6'd4,  6'd2},   // R5
      {3'd0, 3'd1, 3'd3, 6'd4,  6'd4,  6'd4},   // R7 R8 clamp
      {3'd7, 3'd5, 3'd0, 6'd32, 6'd2,  6'd2},   // R6 reserved codes
      {3'd6, 3'd2, 3'd4, 6'd2,  6'd2,  6'd2},   // R6 R7 R8
      {3'd2, 3'd4, 3'd1, 6'd16, 6'd2,  6'd8}    // R5
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [8:0] v, input bit with_end);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v; cycle_end = with_end;
      @(negedge clk);
      cfg_wr = 1'b0; cycle_end = 1'b0;
   endtask

   task automatic bus_end();
      @(negedge clk);
      cycle_end = 1'b1;
      @(negedge clk);
      cycle_end = 1'b0;
   endtask

   task automatic measure(input int e0, input int e1, input int e2, input string req);
      int c0 = 0, c1 = 0, c2 = 0, adj = 0, mis = 0;
      bit prev = 1'b0;
      repeat (32) begin
         @(negedge clk);
         c0 += int'(core_en); c1 += int'(per_en); c2 += int'(ext_en);
         if (core_en && prev) adj++;
         if ((per_en || ext_en) && !core_en) mis++;
         prev = core_en;
      end
      chk(c0 == e0, {req, " core"}, c0, e0);
      chk(c1 == e1, {req, " per"}, c1, e1);
      chk(c2 == e2, {req, " ext"}, c2, e2);
      chk(mis == 0, "R9 alignment", mis, 0);
      if (e0 < 32) chk(adj == 0, "R10 width", adj, 0);
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(cfg_rdata == 9'h049, "R1 rdata", int'(cfg_rdata), 'h049);
      measure(16, 16, 16, "R1");

      for (int i = 0; i < 6; i++) begin
         wr_cfg(VEC[i][26:18], 1'b0);
         // R2 raw read-back
         chk(cfg_rdata == VEC[i][26:18], "R2 rdata", int'(cfg_rdata), int'(VEC[i][26:18]));
         bus_end();
         measure(int'(VEC[i][17:12]), int'(VEC[i][11:6]), int'(VEC[i][5:0]), "R5-vec");
      end

      // R4: write coinciding with cycle_end keeps old setting (16,2,8)
      wr_cfg(9'h000, 1'b1);
      chk(cfg_rdata == 9'h000, "R2 rdata", int'(cfg_rdata), 0);
      measure(16, 2, 8, "R4 same-cycle");
      bus_end();
      measure(32, 32, 32, "R4 applied");

      // R3: no change before cycle_end
      wr_cfg(9'h092, 1'b0);
      measure(32, 32, 32, "R3 held");
      bus_end();
      measure(8, 8, 8, "R3 applied");

      // R1 again after a second reset
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(cfg_rdata == 9'h049, "R1 rdata re-reset", int'(cfg_rdata), 'h049);
      measure(16, 16, 16, "R1 re-reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule